// File: doc/BRIEF.md
# Receive Frame Size Check and Statistics

This block is given one event per received frame: the frame length without its FCS, a kind code for broadcast, multicast or other addressing, and a good-frame flag. In the same cycle it decides whether the frame is oversized. The decision uses a standard limit or a long limit, picked by a long-frame configuration bit. A keep-bad-frames bit turns the check off.

It keeps a set of saturating receive statistics counters. Six count good frames by length class. Others count total and good frames, broadcast and multicast frames, and oversized frames. Two wide counters accumulate total and good octets.

Software-side logic reads the counters through a registered read port. Each wide octet counter takes two reads. Reading its low half captures the high half, so the two halves stay consistent.

Top module: `rx_stats`

## Requirements
- R1: With `cfg_long_en` low and `cfg_store_bad` low, `ev_oversize` is high, combinationally in the event cycle, exactly when `ev_len` exceeds 1518.
- R2: With `cfg_long_en` high and `cfg_store_bad` low, `ev_oversize` is high exactly when `ev_len` exceeds 16380.
- R3: With `cfg_store_bad` high, `ev_oversize` stays low for every length.
- R4: Every valid oversized event increments the oversize counter (address 10), whatever `ev_good` is. An oversized event changes no other counter.
- R5: A valid, good, non-oversized event is binned on its length plus 4 bytes of FCS. The bins are exactly 64 (address 0), 65–127 (1), 128–255 (2), 256–511 (3), 512–1023 (4) and above 1023 (5). A binned length below 64 increments no bin.
- R6: A valid, good, non-oversized event increments the total-frames counter (address 6) and the good-frames counter (address 7). If `ev_kind` is 1 (broadcast) it also increments address 8; if `ev_kind` is 2 (multicast) it also increments address 9. Kind 0 and kind 3 touch neither of those two.
- R7: Such an event adds `ev_len`+4 to both octet counters: total octets (low half at address 11, high half at 12) and good octets (low half at 13, high half at 14).
- R8: Every counter saturates at its all-ones value and never wraps.
- R9: A read with `rd_en` high presents the addressed value on `rd_data` after the next rising edge. Counters narrower than `RD_W` are zero-extended, and address 15 reads as zero.
- R10: Reading a low-half address captures the matching octet counter's upper bits. A later read of the high-half address returns that captured value, even if the counter has changed in between.
- R11: After reset, every counter and captured half is zero. A cycle with `clr` high zeroes them all as well, and an event in that cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all counters and captured halves |
| cfg_long_en | input | 1 | Selects the long oversize limit |
| cfg_store_bad | input | 1 | Turns off the oversize check |
| ev_valid | input | 1 | Frame event strobe |
| ev_len | input | LEN_W | Frame length in bytes, FCS excluded |
| ev_kind | input | 2 | 0 other, 1 broadcast, 2 multicast |
| ev_good | input | 1 | Frame was received without error |
| ev_oversize | output | 1 | Oversize decision for the current event |
| rd_en | input | 1 | Read request |
| rd_addr | input | 4 | Read address |
| rd_data | output | RD_W | Registered read data |

## Verification
The bench builds the block with 8-bit event counters, a 16-bit octet accumulator and an 8-bit read port. A few hundred random frames therefore drive the frame counters into saturation. A handful of long frames pins the octet counters at their ceiling. The narrow read port turns each octet counter into a real split into low and high halves, so the capture of the upper bits can be observed across intervening events. Directed frames sit on each side of both oversize limits and of every bin edge.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
   localparam int NUM_BINS = 6;
   localparam int NUM_CTR  = 11;
   localparam int ADDR_W   = 4;
   localparam int FCS_LEN  = 4;

   localparam int C_TOTAL = 6;
   localparam int C_GOOD  = 7;
   localparam int C_BCAST = 8;
   localparam int C_MCAST = 9;
   localparam int C_OVER  = 10;

   localparam logic [ADDR_W-1:0] A_TOT_LO  = 4'd11;
   localparam logic [ADDR_W-1:0] A_TOT_HI  = 4'd12;
   localparam logic [ADDR_W-1:0] A_GOOD_LO = 4'd13;
   localparam logic [ADDR_W-1:0] A_GOOD_HI = 4'd14;

   typedef enum logic [1:0] {
      KIND_OTHER = 2'd0,
      KIND_BCAST = 2'd1,
      KIND_MCAST = 2'd2
   } frame_kind_e;

   function automatic int bin_floor(input int idx);
      case (idx)
         0: return 64;
         1: return 65;
         2: return 128;
         3: return 256;
         4: return 512;
         default: return 1024;
      endcase
   endfunction
endpackage

// File: rtl/rxs_classify.sv
module rxs_classify
   import rxs_pkg::*;
#(
   parameter int LEN_W   = 16,
   parameter int MAX_STD = 1518,
   parameter int MAX_LONG = 16380
) (
   input  logic [LEN_W-1:0]    len_i,
   input  logic                long_en_i,
   input  logic                store_bad_i,
   output logic                over_o,
   output logic [NUM_BINS-1:0] bin_o
);
   localparam int FL_W = LEN_W + 1;

   logic [FL_W-1:0] flen;
   logic            over_std, over_long;

   assign flen      = FL_W'(len_i) + FL_W'(FCS_LEN);
   assign over_std  = FL_W'(len_i) > FL_W'(MAX_STD);
   assign over_long = FL_W'(len_i) > FL_W'(MAX_LONG);
   assign over_o    = !store_bad_i && (over_long || (!long_en_i && over_std));

   for (genvar b = 0; b < NUM_BINS; b++) begin : g_bin
      if (b == NUM_BINS - 1) begin : g_top
         assign bin_o[b] = flen >= FL_W'(bin_floor(b));
      end else begin : g_mid
         assign bin_o[b] = (flen >= FL_W'(bin_floor(b))) &&
                           (flen <  FL_W'(bin_floor(b + 1)));
      end
   end

   always_comb begin
      p_bin_onehot_r5: assert ($onehot0(bin_o));
   end
endmodule

// File: rtl/rxs_sat_ctr.sv
module rxs_sat_ctr #(
   parameter int W     = 32,
   parameter int INC_W = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc_en,
   input  logic [INC_W-1:0] inc_val,
   output logic [W-1:0]     q
);
   localparam int SW = ((W > INC_W) ? W : INC_W) + 1;
   localparam logic [W-1:0] Q_MAX = '1;

   logic [SW-1:0] sum;
   assign sum = SW'(q) + SW'(inc_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= '0;
      else if (clr)    q <= '0;
      else if (inc_en) q <= (sum > SW'(Q_MAX)) ? Q_MAX : sum[W-1:0];
   end

   p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> q >= $past(q));
   p_sat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && q == Q_MAX) |=> q == Q_MAX);
   p_clr_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> q == '0);
endmodule

// File: rtl/rxs_readout.sv
module rxs_readout
   import rxs_pkg::*;
#(
   parameter int CNT_W = 32,
   parameter int OCT_W = 64,
   parameter int RD_W  = 32
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          clr,
   input  logic                          rd_en,
   input  logic [ADDR_W-1:0]             rd_addr,
   input  logic [NUM_CTR-1:0][CNT_W-1:0] ctr_q,
   input  logic [OCT_W-1:0]              oct_tot,
   input  logic [OCT_W-1:0]              oct_good,
   output logic [RD_W-1:0]               rd_data
);
   localparam int HI_W = OCT_W - RD_W;

   logic [RD_W-1:0] snap_tot, snap_good, rd_next;

   always_comb begin
      rd_next = '0;
      for (int i = 0; i < NUM_CTR; i++) begin
         if (rd_addr == ADDR_W'(i)) rd_next = RD_W'(ctr_q[i]);
      end
      case (rd_addr)
         A_TOT_LO:  rd_next = oct_tot[RD_W-1:0];
         A_TOT_HI:  rd_next = snap_tot;
         A_GOOD_LO: rd_next = oct_good[RD_W-1:0];
         A_GOOD_HI: rd_next = snap_good;
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data   <= '0;
         snap_tot  <= '0;
         snap_good <= '0;
      end else begin
         if (rd_en) rd_data <= rd_next;
         if (clr) begin
            snap_tot  <= '0;
            snap_good <= '0;
         end else if (rd_en) begin
            if (rd_addr == A_TOT_LO)  snap_tot  <= RD_W'(oct_tot[OCT_W-1:RD_W]);
            if (rd_addr == A_GOOD_LO) snap_good <= RD_W'(oct_good[OCT_W-1:RD_W]);
         end
      end
   end

   p_snap_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !(rd_en && rd_addr == A_TOT_LO)) |=> $stable(snap_tot));
   p_snap_hold_good_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !(rd_en && rd_addr == A_GOOD_LO)) |=> $stable(snap_good));
   p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data));

   if (HI_W < 1 || HI_W > RD_W) begin : g_bad_hi
      $error("OCT_W must lie in (RD_W, 2*RD_W]");
   end
endmodule

// File: rtl/rx_stats.sv
module rx_stats
   import rxs_pkg::*;
#(
   parameter int LEN_W    = 16,
   parameter int CNT_W    = 32,
   parameter int OCT_W    = 64,
   parameter int RD_W     = 32,
   parameter int MAX_STD  = 1518,
   parameter int MAX_LONG = 16380
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              cfg_long_en,
   input  logic              cfg_store_bad,
   input  logic              ev_valid,
   input  logic [LEN_W-1:0]  ev_len,
   input  logic [1:0]        ev_kind,
   input  logic              ev_good,
   output logic              ev_oversize,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [RD_W-1:0]   rd_data
);
   localparam int OCT_INC_W = LEN_W + 1;
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   if (CNT_W > RD_W) begin : g_bad_cnt
      $error("CNT_W must not exceed RD_W");
   end
   if (MAX_LONG >= (1 << LEN_W) || MAX_STD >= MAX_LONG) begin : g_bad_lim
      $error("oversize limits do not fit LEN_W");
   end

   logic [NUM_BINS-1:0]          bin_hit;
   logic                         stat_upd;
   logic [NUM_CTR-1:0]           ctr_inc;
   logic [NUM_CTR-1:0][CNT_W-1:0] ctr_q;
   logic [OCT_INC_W-1:0]         oct_add;
   logic [OCT_W-1:0]             oct_tot, oct_good;

   rxs_classify #(.LEN_W(LEN_W), .MAX_STD(MAX_STD), .MAX_LONG(MAX_LONG)) u_cls (
      .len_i      (ev_len),
      .long_en_i  (cfg_long_en),
      .store_bad_i(cfg_store_bad),
      .over_o     (ev_oversize),
      .bin_o      (bin_hit)
   );

   assign stat_upd = ev_valid && ev_good && !ev_oversize;
   assign oct_add  = OCT_INC_W'(ev_len) + OCT_INC_W'(FCS_LEN);

   always_comb begin
      ctr_inc                = '0;
      ctr_inc[NUM_BINS-1:0]  = stat_upd ? bin_hit : '0;
      ctr_inc[C_TOTAL]       = stat_upd;
      ctr_inc[C_GOOD]        = stat_upd;
      ctr_inc[C_BCAST]       = stat_upd && (ev_kind == KIND_BCAST);
      ctr_inc[C_MCAST]       = stat_upd && (ev_kind == KIND_MCAST);
      ctr_inc[C_OVER]        = ev_valid && ev_oversize;
   end

   for (genvar c = 0; c < NUM_CTR; c++) begin : g_ctr
      rxs_sat_ctr #(.W(CNT_W), .INC_W(1)) u_ctr (
         .clk, .rst_n, .clr,
         .inc_en (ctr_inc[c]),
         .inc_val(1'b1),
         .q      (ctr_q[c])
      );
   end

   rxs_sat_ctr #(.W(OCT_W), .INC_W(OCT_INC_W)) u_oct_tot (
      .clk, .rst_n, .clr,
      .inc_en(stat_upd), .inc_val(oct_add), .q(oct_tot)
   );
   rxs_sat_ctr #(.W(OCT_W), .INC_W(OCT_INC_W)) u_oct_good (
      .clk, .rst_n, .clr,
      .inc_en(stat_upd), .inc_val(oct_add), .q(oct_good)
   );

   rxs_readout #(.CNT_W(CNT_W), .OCT_W(OCT_W), .RD_W(RD_W)) u_rd (
      .clk, .rst_n, .clr, .rd_en, .rd_addr,
      .ctr_q, .oct_tot, .oct_good, .rd_data
   );

   p_over_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && ev_oversize && !clr && ctr_q[C_OVER] != CNT_MAX)
      |=> ctr_q[C_OVER] == $past(ctr_q[C_OVER]) + CNT_W'(1));
   p_over_no_stats_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && ev_oversize && !clr)
      |=> ($stable(ctr_q[C_GOOD]) && $stable(oct_good)));
endmodule

// File: tb/rx_stats_tb.sv
module rx_stats_tb;
   localparam int LEN_W = 16;
   localparam int CNT_W = 8;
   localparam int OCT_W = 16;
   localparam int RD_W  = 8;
   localparam int CMAX  = (1 << CNT_W) - 1;
   localparam int OMAX  = (1 << OCT_W) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic clr = 1'b0, cfg_long_en = 1'b0, cfg_store_bad = 1'b0;
   logic ev_valid = 1'b0, ev_good = 1'b0;
   logic [LEN_W-1:0] ev_len = '0;
   logic [1:0] ev_kind = '0;
   logic ev_oversize;
   logic rd_en = 1'b0;
   logic [3:0] rd_addr = '0;
   logic [RD_W-1:0] rd_data;

   int n_chk = 0, n_fail = 0;
   int exp_c[11];
   int exp_ot = 0, exp_og = 0, snap_t = 0, snap_g = 0;

   always #10 clk = ~clk;

   rx_stats #(.LEN_W(LEN_W), .CNT_W(CNT_W), .OCT_W(OCT_W), .RD_W(RD_W)) u_dut (
      .clk, .rst_n, .clr, .cfg_long_en, .cfg_store_bad, .ev_valid, .ev_len,
      .ev_kind, .ev_good, .ev_oversize, .rd_en, .rd_addr, .rd_data
   );

   function automatic bit model_over(int len, bit lpe, bit sbp);
      if (sbp) return 1'b0;
      return (len > 16380) || (!lpe && len > 1518);
   endfunction

   function automatic int model_bin(int flen);
      if (flen < 64) return -1;
      if (flen == 64) return 0;
      if (flen < 128) return 1;
      if (flen < 256) return 2;
      if (flen < 512) return 3;
      if (flen < 1024) return 4;
      return 5;
   endfunction

   function automatic int sat(int v, int mx);
      return (v > mx) ? mx : v;
   endfunction

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic model_clear();
      for (int i = 0; i < 11; i++) exp_c[i] = 0;
      exp_ot = 0; exp_og = 0; snap_t = 0; snap_g = 0;
   endtask

   // R1 R2 R3 checked on ev_oversize; R4 R5 R6 R7 R8 update the model
   task automatic send(int len, int kind, bit good);
      bit ov;
      int b;
      @(negedge clk);
      ev_valid = 1'b1; ev_len = LEN_W'(len); ev_kind = 2'(kind); ev_good = good;
      #1;
      ov = model_over(len, cfg_long_en, cfg_store_bad);
      check(cfg_store_bad ? "R3" : (cfg_long_en ? "R2" : "R1"), int'(ev_oversize), int'(ov));
      if (ov) exp_c[10] = sat(exp_c[10] + 1, CMAX);
      else if (good) begin
         b = model_bin(len + 4);
         if (b >= 0) exp_c[b] = sat(exp_c[b] + 1, CMAX);
         exp_c[6] = sat(exp_c[6] + 1, CMAX);
         exp_c[7] = sat(exp_c[7] + 1, CMAX);
         if (kind == 1) exp_c[8] = sat(exp_c[8] + 1, CMAX);
         if (kind == 2) exp_c[9] = sat(exp_c[9] + 1, CMAX);
         exp_ot = sat(exp_ot + len + 4, OMAX);
         exp_og = sat(exp_og + len + 4, OMAX);
      end
      @(posedge clk); #1;
      ev_valid = 1'b0;
   endtask

   task automatic rd(int addr, string req);
      int e;
      @(negedge clk);
      rd_en = 1'b1; rd_addr = 4'(addr);
      @(posedge clk); #1;
      rd_en = 1'b0;
      if (addr <= 10) e = exp_c[addr];
      else if (addr == 11) begin e = exp_ot & 255; snap_t = exp_ot >> 8; end
      else if (addr == 12) e = snap_t;
      else if (addr == 13) begin e = exp_og & 255; snap_g = exp_og >> 8; end
      else if (addr == 14) e = snap_g;
      else e = 0;
      @(negedge clk);
      check(req, int'(rd_data), e);
   endtask

   task automatic rd_all(string req);
      for (int a = 0; a < 16; a++) rd(a, req);
   endtask

   initial begin
      model_clear();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      rd_all("R11 reset");

      // R1 boundary
      send(1518, 0, 1); send(1519, 0, 1);
      // R2 boundary
      cfg_long_en = 1'b1;
      send(16380, 0, 1); send(16381, 0, 0);
      // R3
      cfg_store_bad = 1'b1; send(20000, 0, 1); send(3000, 0, 1);
      cfg_store_bad = 1'b0; cfg_long_en = 1'b0;
      rd_all("R4 R7 R9");
      @(negedge clk); clr = 1'b1; @(posedge clk); #1 clr = 1'b0;
      model_clear();
      // R5 bin edges, R6 kinds, R7 octets before saturation
      send(59, 0, 1); send(60, 1, 1); send(61, 2, 1); send(123, 3, 1);
      send(124, 1, 1); send(251, 2, 1); send(252, 0, 1); send(507, 1, 1);
      send(508, 2, 1); send(1019, 0, 1); send(1020, 1, 1); send(200, 2, 0);
      rd_all("R5 R6 R7");
      // R10: capture high, then change counter, high read returns capture
      rd(11, "R10"); rd(13, "R10");
      send(900, 0, 1);
      rd(12, "R10"); rd(14, "R10");
      // random traffic into saturation (R8)
      for (int i = 0; i < 400; i++) begin
         int r, len;
         r = $urandom_range(0, 9);
         case (r)
            0: len = $urandom_range(0, 59);
            1, 2: len = $urandom_range(60, 300);
            3, 4: len = $urandom_range(301, 1600);
            5: len = $urandom_range(1500, 1530);
            6: len = $urandom_range(16370, 16400);
            default: len = $urandom_range(60, 1000);
         endcase
         cfg_long_en = ($urandom_range(0, 3) == 0);
         send(len, $urandom_range(0, 3), ($urandom_range(0, 7) != 0));
      end
      cfg_long_en = 1'b0;
      rd_all("R8");
      send(100, 1, 1); send(20000, 0, 1);
      rd_all("R8 saturated");
      // R11 clear with event in the same cycle
      @(negedge clk);
      clr = 1'b1; ev_valid = 1'b1; ev_len = 16'd100; ev_good = 1'b1; ev_kind = 2'd1;
      @(posedge clk); #1;
      clr = 1'b0; ev_valid = 1'b0;
      model_clear();
      rd_all("R11 clear");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      #(20 * 190000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule